// File: doc/BRIEF.md
# Per-Phase Fault Interruption Mode Manager

This block supervises the phases of a series voltage compensator that sits between a supply and a sensitive load. Each phase gets its own identical supervisor. It watches the sampled instantaneous line current of that phase and the sag flag from an upstream sag detector, and it picks one of three operating modes: standby, sag compensation, or fault current interruption.

When a downstream overcurrent persists, the phase switches to interruption. In that mode the compensator is told to inject a voltage equal in magnitude to the source voltage and opposite in phase, which drives the load-side voltage to zero. A trip request then goes to the upstream breaker, so the compensator is not bypassed. The interruption state is held until an external clear arrives for that phase.

Phasor estimation, the control loops and pulse-width modulation are handled elsewhere. This block only produces the mode code, the anti-phase reference select and the trip request.

Top module: `fci_mode_mgr`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released with no inputs active, every mode_o field reads 2'b00 (standby), anti_o is all zero and trip_o is 0.
- R2: A sample exceeds the limit only when the magnitude of the signed two's-complement sample is strictly greater than thr_i. A magnitude equal to thr_i does not count. The most negative code counts as its full magnitude.
- R3: A phase detects a fault after DEB consecutive valid samples (smp_vld_i high) that exceed the limit. A valid sample that does not exceed the limit restarts the count. Cycles with smp_vld_i low neither advance nor restart it.
- R4: Interruption is entered on the clock edge after the one that captures the last sample completing detection. A phase in interruption shows mode_o = 2'b10 and anti_o = 1 (source magnitude, source angle plus 180 degrees). The code 2'b11 never appears.
- R5: A phase not in interruption shows 2'b01 (sag compensation) while its sag_i is high, and 2'b00 otherwise. Interruption overrides sag compensation.
- R6: Interruption stays latched after the current falls. clr_i of that phase ends it on the next edge and also restarts its sample count. A clear wins over a detection on the same edge.
- R7: trip_o is high exactly while at least one phase is in interruption.
- R8: A fault on one phase does not change the mode of any other phase.
- R9: With sp_en_i low, a detecting phase enters interruption only if at least two phases are detecting or already interrupting. With sp_en_i high, a single phase enters alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | New current sample on all phases this cycle |
| cur_i | input | NPH*CW | Signed instantaneous current sample per phase |
| thr_i | input | CW | Overcurrent limit (twice rated load current), unsigned |
| sag_i | input | NPH | Upstream sag present, per phase |
| sp_en_i | input | 1 | Allow interruption driven by a single faulty phase |
| clr_i | input | NPH | Fault cleared, ends interruption, per phase |
| mode_o | output | NPH*2 | Mode per phase: 00 standby, 01 sag, 10 interruption |
| anti_o | output | NPH | Select anti-phase source reference, per phase |
| trip_o | output | 1 | Trip request to upstream breaker |

## Verification
The bench builds the block with three phases, a 12-bit sample width and a detection depth of two. The narrow width makes the most negative code (-2048) and the full positive swing easy to drive against a limit of 1000. The depth of two makes it practical to cover the restart after an in-range sample, idle sample slots, and the timing of a clear against a completed detection. Three phases make it possible to test two-phase simultaneous detection with single-phase interruption disabled, and to confirm that the healthy phase stays untouched.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_SAG  = 2'b01,
    MODE_INT  = 2'b10
  } mode_e;
endpackage

// File: rtl/fci_ovc_det.sv
module fci_ovc_det #(
  parameter int CW  = 16,
  parameter int DEB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [CW-1:0] smp_i,
  input  logic [CW-1:0] thr_i,
  input  logic          clr_i,
  output logic          det_o
);
  localparam int CNTW = $clog2(DEB + 1);
  localparam logic [CNTW-1:0] CMAX = CNTW'(DEB);
  localparam logic [CW-1:0]   ONE  = CW'(1);

  logic [CW-1:0]   mag;
  logic            over;
  logic [CNTW-1:0] cnt_q;

  // two's-complement magnitude; most negative code maps to 2^(CW-1)
  assign mag  = smp_i[CW-1] ? (~smp_i + ONE) : smp_i;
  assign over = mag > thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (vld_i) begin
      if (!over)              cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + CNTW'(1);
    end
  end

  assign det_o = (cnt_q == CMAX);
endmodule

// File: rtl/fci_sp_gate.sv
module fci_sp_gate #(
  parameter int NPH = 3
) (
  input  logic [NPH-1:0] det_i,
  input  logic [NPH-1:0] act_i,
  input  logic           sp_en_i,
  output logic           allow_o
);
  localparam int SW = $clog2(NPH + 1);

  logic [SW-1:0] n_hit;

  always_comb begin
    n_hit = '0;
    for (int i = 0; i < NPH; i++)
      if (det_i[i] || act_i[i]) n_hit = n_hit + SW'(1);
  end

  // multi-phase events always pass; lone ones only when enabled
  assign allow_o = sp_en_i || (n_hit >= SW'(2));
endmodule

// File: rtl/fci_phase_ctl.sv
module fci_phase_ctl
  import fci_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  det_i,
  input  logic  allow_i,
  input  logic  clr_i,
  input  logic  sag_i,
  output mode_e mode_o,
  output logic  anti_o
);
  logic int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                int_q <= 1'b0;
    else if (clr_i)             int_q <= 1'b0;
    else if (det_i && allow_i)  int_q <= 1'b1;
  end

  always_comb begin
    if (int_q)      mode_o = MODE_INT;
    else if (sag_i) mode_o = MODE_SAG;
    else            mode_o = MODE_STBY;
  end

  assign anti_o = int_q;
endmodule

// File: rtl/fci_mode_mgr.sv
module fci_mode_mgr
  import fci_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 16,
  parameter int DEB = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      smp_vld_i,
  input  logic [NPH-1:0][CW-1:0]    cur_i,
  input  logic [CW-1:0]             thr_i,
  input  logic [NPH-1:0]            sag_i,
  input  logic                      sp_en_i,
  input  logic [NPH-1:0]            clr_i,
  output logic [NPH-1:0][1:0]       mode_o,
  output logic [NPH-1:0]            anti_o,
  output logic                      trip_o
);
  logic [NPH-1:0] det;
  logic           allow;

  fci_sp_gate #(.NPH(NPH)) u_gate (
    .det_i   (det),
    .act_i   (anti_o),
    .sp_en_i (sp_en_i),
    .allow_o (allow)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    mode_e ph_mode;

    fci_ovc_det #(.CW(CW), .DEB(DEB)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (smp_vld_i),
      .smp_i  (cur_i[p]),
      .thr_i  (thr_i),
      .clr_i  (clr_i[p]),
      .det_o  (det[p])
    );

    fci_phase_ctl u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .det_i   (det[p]),
      .allow_i (allow),
      .clr_i   (clr_i[p]),
      .sag_i   (sag_i[p]),
      .mode_o  (ph_mode),
      .anti_o  (anti_o[p])
    );

    assign mode_o[p] = ph_mode;
  end

  assign trip_o = |anti_o;
endmodule

// File: rtl/fci_mode_mgr_chk.sv
module fci_mode_mgr_chk #(
  parameter int NPH = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NPH-1:0]      sag_i,
  input logic [NPH-1:0]      clr_i,
  input logic [NPH-1:0][1:0] mode_o,
  input logic [NPH-1:0]      anti_o,
  input logic                trip_o
);
  logic any_int;

  always_comb begin
    any_int = 1'b0;
    for (int i = 0; i < NPH; i++)
      if (mode_o[i] == 2'b10) any_int = 1'b1;
  end

  // R7
  trip_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o == any_int);

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    // R4
    anti_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      anti_o[p] == (mode_o[p] == 2'b10));
    // R4
    mode_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o[p] != 2'b11);
    // R5
    sag_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o[p] != 2'b10 && sag_i[p]) |-> mode_o[p] == 2'b01);
    // R6
    int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o[p] == 2'b10 && !clr_i[p]) |=> mode_o[p] == 2'b10);
    // R6
    clr_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[p] |=> mode_o[p] != 2'b10);
  end
endmodule

bind fci_mode_mgr fci_mode_mgr_chk #(.NPH(NPH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sag_i  (sag_i),
  .clr_i  (clr_i),
  .mode_o (mode_o),
  .anti_o (anti_o),
  .trip_o (trip_o)
);

// File: tb/fci_mode_mgr_test.sv
`timescale 1ns/1ps
module fci_mode_mgr_test;
  localparam int NPH = 3;
  localparam int CW  = 12;
  localparam int DEB = 2;
  localparam logic [1:0] ST = 2'd0, SG = 2'd1, FI = 2'd2;

  typedef struct packed {
    logic                 vld;
    logic [2:0]           sag;
    logic                 spen;
    logic [2:0]           clr;
    logic [CW-1:0]        c0;
    logic [CW-1:0]        c1;
    logic [CW-1:0]        c2;
    logic [1:0]           m0;
    logic [1:0]           m1;
    logic [1:0]           m2;
    logic                 trip;
    logic [3:0]           req;
  } vec_t;

  localparam int NV = 28;
  localparam logic [CW-1:0] Z = '0;
  localparam logic [CW-1:0] EQ = 12'd1000, HI = 12'd1001, LO = -12'sd1001;
  localparam logic [CW-1:0] BIG = 12'd1500, PMAX = 12'd2047, NMIN = 12'h800;

  localparam vec_t TBL [NV] = '{
    // R1 idle
    '{1'b1, 3'b000, 1'b1, 3'b000, Z,    Z,    Z,    ST, ST, ST, 1'b0, 4'd1},
    // R5 sag on phase 0
    '{1'b1, 3'b001, 1'b1, 3'b000, Z,    Z,    Z,    SG, ST, ST, 1'b0, 4'd5},
    // R2 equal to limit does not count
    '{1'b1, 3'b001, 1'b1, 3'b000, EQ,   Z,    Z,    SG, ST, ST, 1'b0, 4'd2},
    '{1'b1, 3'b001, 1'b1, 3'b000, EQ,   Z,    Z,    SG, ST, ST, 1'b0, 4'd2},
    // R3 one over, then in-range restarts
    '{1'b1, 3'b001, 1'b1, 3'b000, HI,   Z,    Z,    SG, ST, ST, 1'b0, 4'd3},
    '{1'b1, 3'b001, 1'b1, 3'b000, Z,    Z,    Z,    SG, ST, ST, 1'b0, 4'd3},
    // R3 negative over, idle slot, negative over
    '{1'b1, 3'b001, 1'b1, 3'b000, LO,   Z,    Z,    SG, ST, ST, 1'b0, 4'd3},
    '{1'b0, 3'b001, 1'b1, 3'b000, Z,    Z,    Z,    SG, ST, ST, 1'b0, 4'd3},
    '{1'b1, 3'b001, 1'b1, 3'b000, LO,   Z,    Z,    SG, ST, ST, 1'b0, 4'd4},
    // R4 R8 enter interruption, overriding sag
    '{1'b1, 3'b001, 1'b1, 3'b000, Z,    Z,    Z,    FI, ST, ST, 1'b1, 4'd4},
    // R6 latched
    '{1'b1, 3'b000, 1'b1, 3'b000, Z,    Z,    Z,    FI, ST, ST, 1'b1, 4'd6},
    // R6 clear
    '{1'b1, 3'b000, 1'b1, 3'b001, Z,    Z,    Z,    ST, ST, ST, 1'b0, 4'd6},
    '{1'b1, 3'b000, 1'b1, 3'b000, Z,    Z,    Z,    ST, ST, ST, 1'b0, 4'd7},
    // R9 single phase with enable low
    '{1'b1, 3'b000, 1'b0, 3'b000, Z,    PMAX, Z,    ST, ST, ST, 1'b0, 4'd9},
    '{1'b1, 3'b000, 1'b0, 3'b000, Z,    PMAX, Z,    ST, ST, ST, 1'b0, 4'd9},
    '{1'b1, 3'b000, 1'b0, 3'b000, Z,    PMAX, Z,    ST, ST, ST, 1'b0, 4'd9},
    '{1'b1, 3'b000, 1'b0, 3'b000, Z,    PMAX, NMIN, ST, ST, ST, 1'b0, 4'd9},
    '{1'b1, 3'b000, 1'b0, 3'b000, Z,    PMAX, NMIN, ST, ST, ST, 1'b0, 4'd9},
    // R9 R2 two phases, most negative code
    '{1'b1, 3'b000, 1'b0, 3'b000, Z,    PMAX, NMIN, ST, FI, FI, 1'b1, 4'd9},
    // R8 R7 clear one phase only
    '{1'b1, 3'b000, 1'b0, 3'b010, Z,    Z,    Z,    ST, ST, FI, 1'b1, 4'd8},
    '{1'b1, 3'b000, 1'b0, 3'b100, Z,    Z,    Z,    ST, ST, ST, 1'b0, 4'd7},
    // R6 clear wins over completed detection
    '{1'b1, 3'b000, 1'b1, 3'b000, BIG,  Z,    Z,    ST, ST, ST, 1'b0, 4'd6},
    '{1'b1, 3'b000, 1'b1, 3'b000, BIG,  Z,    Z,    ST, ST, ST, 1'b0, 4'd6},
    '{1'b1, 3'b000, 1'b1, 3'b001, BIG,  Z,    Z,    ST, ST, ST, 1'b0, 4'd6},
    '{1'b1, 3'b000, 1'b1, 3'b000, BIG,  Z,    Z,    ST, ST, ST, 1'b0, 4'd6},
    '{1'b1, 3'b000, 1'b1, 3'b000, BIG,  Z,    Z,    ST, ST, ST, 1'b0, 4'd3},
    // R5 interruption overrides sag
    '{1'b1, 3'b001, 1'b1, 3'b000, Z,    Z,    Z,    FI, ST, ST, 1'b1, 4'd5},
    '{1'b1, 3'b001, 1'b1, 3'b001, Z,    Z,    Z,    SG, ST, ST, 1'b0, 4'd6}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni;
  logic                   smp_vld_i;
  logic [NPH-1:0][CW-1:0] cur_i;
  logic [CW-1:0]          thr_i;
  logic [NPH-1:0]         sag_i;
  logic                   sp_en_i;
  logic [NPH-1:0]         clr_i;
  logic [NPH-1:0][1:0]    mode_o;
  logic [NPH-1:0]         anti_o;
  logic                   trip_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  fci_mode_mgr #(.NPH(NPH), .CW(CW), .DEB(DEB)) uut (
    .clk_i, .rst_ni, .smp_vld_i, .cur_i, .thr_i, .sag_i,
    .sp_en_i, .clr_i, .mode_o, .anti_o, .trip_o
  );

  task automatic drive(input vec_t v);
    smp_vld_i = v.vld;
    sag_i     = v.sag;
    sp_en_i   = v.spen;
    clr_i     = v.clr;
    cur_i[0]  = v.c0;
    cur_i[1]  = v.c1;
    cur_i[2]  = v.c2;
  endtask

  task automatic check(input string tag, input logic [1:0] e0, input logic [1:0] e1,
                       input logic [1:0] e2, input logic etrip);
    logic [NPH-1:0][1:0] em;
    logic [NPH-1:0]      ea;
    em = {e2, e1, e0};
    for (int p = 0; p < NPH; p++) ea[p] = (em[p] == FI);
    total++;
    if (mode_o !== em || anti_o !== ea || trip_o !== etrip) begin
      bad++;
      $display("FAIL %s: mode=%h anti=%b trip=%b expected mode=%h anti=%b trip=%b",
               tag, mode_o, anti_o, trip_o, em, ea, etrip);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    thr_i  = 12'd1000;
    drive('0);
    repeat (3) @(negedge clk_i);
    check("R1 in reset", ST, ST, ST, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", ST, ST, ST, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk_i);
      check($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].m0, TBL[i].m1, TBL[i].m2, TBL[i].trip);
    end

    // R4 fresh fault then R1 async reset clears it
    drive('{1'b1, 3'b000, 1'b1, 3'b000, BIG, Z, Z, ST, ST, ST, 1'b0, 4'd4});
    @(negedge clk_i);
    @(negedge clk_i);
    check("R4 not yet", ST, ST, ST, 1'b0);
    cur_i[0] = Z;
    @(negedge clk_i);
    check("R4 entered", FI, ST, ST, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", ST, ST, ST, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 released", ST, ST, ST, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule